// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This block turns one 512-bit message block into the stream of word pairs that the SM3 compression rounds consume. Each round needs two words: the expanded word W[j] and the derived word W'[j] = W[j] XOR W[j+4]. The unit does not build the full 68-word expansion in storage. It keeps a 16-word sliding window, presents the current pair, and computes one new expanded word each time the compression engine advances.

A block is offered with a valid/ready handshake. While the unit is expanding a block, ready stays low. After the compression engine has consumed the 64th pair, the window is cleared and ready rises again. The compression engine steps through the rounds with a one-cycle advance strobe. The current pair and its round index stay on the outputs until that strobe arrives.

Top module: `sm3x_expand`

## Requirements
- R1: The input block is split into bytes, with byte 0 in `blk_data_i[511:504]`, byte 1 in `[503:496]` and so on. Word i is formed from bytes 4i..4i+3, and the lowest-numbered byte is the most significant, so word 0 equals `blk_data_i[511:480]`.
- R2: For rounds 0 to 15, `w_o` equals input word j.
- R3: For j from 16 to 67, W[j] = P1(W[j-16] ^ W[j-9] ^ rotl(W[j-3],15)) ^ rotl(W[j-13],7) ^ W[j-6]. Here P1(x) = x ^ rotl(x,15) ^ rotl(x,23), and every rotl is a 32-bit circular left rotate. `w_o` in round j equals W[j].
- R4: In every round j from 0 to 63, `wp_o` equals W[j] ^ W[j+4].
- R5: While idle, `blk_ready_o` is 1. When a clock edge sees `blk_valid_i` and `blk_ready_o` both high, the block is captured. From the next cycle, `pair_valid_o` is 1, `round_o` is 0 and `blk_ready_o` is 0.
- R6: Each clock edge that sees `adv_i` high while `pair_valid_o` is high and `round_o` is below 63 moves to the next round: `round_o` increments by one. Without `adv_i`, `w_o`, `wp_o` and `round_o` hold their values.
- R7: Exactly 64 pairs are delivered per block. An advance in round 63 leaves the unit idle on the next cycle, with `pair_valid_o` 0, `blk_ready_o` 1, and `w_o`, `wp_o` and `round_o` all 0.
- R8: `blk_valid_i` and `blk_data_i` have no effect while a block is being expanded, and `adv_i` has no effect while idle.
- R9: After reset, `blk_ready_o` is 1, `pair_valid_o` is 0, and `w_o`, `wp_o` and `round_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| blk_valid_i | input | 1 | Block offered |
| blk_ready_o | output | 1 | Unit idle, block can be taken |
| blk_data_i | input | 512 | Message block, byte 0 in the top bits |
| adv_i | input | 1 | Current pair consumed, step to the next round |
| pair_valid_o | output | 1 | A pair is presented |
| w_o | output | 32 | Expanded word W[j] |
| wp_o | output | 32 | Derived word W[j] ^ W[j+4] |
| round_o | output | 6 | Round index j |

## Verification
The bench compares every round of several blocks against an expanded-word model computed from the recurrence. Some rounds are stalled, which catches a window that shifts without an advance or a lookahead distance off by one in `wp_o`. One block keeps a different block offered on the input throughout its expansion, so a design that accepted a new block mid-run would show corrupted words. The bench also checks the exact byte lane of word 0 against a counting pattern, and checks that an advance in round 63 leaves the outputs zero and ready high; a design that delivered 63 or 65 pairs, or left stale window words behind, fails there.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BLK_WORDS = 16;
  localparam int unsigned BLK_W     = WORD_W * BLK_WORDS;
  localparam int unsigned PAIRS     = 64;
  localparam int unsigned RND_W     = $clog2(PAIRS);
  localparam int unsigned LOOKAHEAD = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [RND_W-1:0]  rnd_t;

  function automatic word_t rotl(word_t x, int unsigned r);
    return (x << r) | (x >> (WORD_W - r));
  endfunction

  function automatic word_t perm1(word_t x);
    return x ^ rotl(x, 15) ^ rotl(x, 23);
  endfunction
endpackage

// File: rtl/sm3x_lane_unpack.sv
module sm3x_lane_unpack
  import sm3x_pkg::*;
#(
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic [BLK_W-1:0] blk_i,
  output word_t            words_o [BLK_WORDS]
);
  localparam int unsigned BYTES_PER_WORD = WORD_W / 8;

  for (genvar w = 0; w < BLK_WORDS; w++) begin : g_word
    for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : g_byte
      localparam int unsigned K = w * BYTES_PER_WORD + b;
      if (MSB_FIRST) begin : g_msb
        assign words_o[w][WORD_W-1-8*b -: 8] = blk_i[BLK_W-1-8*K -: 8];
      end else begin : g_lsb
        assign words_o[w][WORD_W-1-8*b -: 8] = blk_i[8*K +: 8];
      end
    end
  end
endmodule

// File: rtl/sm3x_round_ctrl.sv
module sm3x_round_ctrl
  import sm3x_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blk_valid_i,
  input  logic adv_i,
  output logic busy_o,
  output logic load_o,
  output logic shift_o,
  output logic clear_o,
  output rnd_t round_o
);
  localparam rnd_t LAST_RND = rnd_t'(PAIRS - 1);

  logic busy_q;
  rnd_t round_q;
  logic last_step;

  assign last_step = busy_q & adv_i & (round_q == LAST_RND);
  assign load_o    = blk_valid_i & ~busy_q;
  assign shift_o   = busy_q & adv_i & ~last_step;
  assign clear_o   = last_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      round_q <= '0;
    end else if (load_o) begin
      busy_q  <= 1'b1;
      round_q <= '0;
    end else if (last_step) begin
      busy_q  <= 1'b0;
      round_q <= '0;
    end else if (shift_o) begin
      round_q <= round_q + rnd_t'(1);
    end
  end

  assign busy_o  = busy_q;
  assign round_o = round_q;
endmodule

// File: rtl/sm3x_window.sv
module sm3x_window
  import sm3x_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  shift_i,
  input  logic  clear_i,
  input  word_t words_i [BLK_WORDS],
  output word_t w_o,
  output word_t wp_o
);
  // win_q[k] holds W[j+k] while round j is presented
  word_t win_q [BLK_WORDS];
  word_t next_w;

  always_comb begin
    next_w = perm1(win_q[0] ^ win_q[7] ^ rotl(win_q[13], 15))
           ^ rotl(win_q[3], 7) ^ win_q[10];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BLK_WORDS; i++) win_q[i] <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < BLK_WORDS; i++) win_q[i] <= '0;
    end else if (load_i) begin
      for (int i = 0; i < BLK_WORDS; i++) win_q[i] <= words_i[i];
    end else if (shift_i) begin
      for (int i = 0; i < BLK_WORDS - 1; i++) win_q[i] <= win_q[i+1];
      win_q[BLK_WORDS-1] <= next_w;
    end
  end

  assign w_o  = win_q[0];
  assign wp_o = win_q[0] ^ win_q[LOOKAHEAD];
endmodule

// File: rtl/sm3x_expand.sv
module sm3x_expand
  import sm3x_pkg::*;
#(
  parameter bit LANE_MSB_FIRST = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               blk_valid_i,
  output logic               blk_ready_o,
  input  logic [BLK_W-1:0]   blk_data_i,
  input  logic               adv_i,
  output logic               pair_valid_o,
  output logic [WORD_W-1:0]  w_o,
  output logic [WORD_W-1:0]  wp_o,
  output logic [RND_W-1:0]   round_o
);
  word_t words [BLK_WORDS];
  logic  busy, load, shift, clear;
  rnd_t  round;
  word_t w_cur, wp_cur;

  sm3x_lane_unpack #(.MSB_FIRST(LANE_MSB_FIRST)) u_unpack (
    .blk_i   (blk_data_i),
    .words_o (words)
  );

  sm3x_round_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .blk_valid_i (blk_valid_i),
    .adv_i       (adv_i),
    .busy_o      (busy),
    .load_o      (load),
    .shift_o     (shift),
    .clear_o     (clear),
    .round_o     (round)
  );

  sm3x_window u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .clear_i (clear),
    .words_i (words),
    .w_o     (w_cur),
    .wp_o    (wp_cur)
  );

  assign blk_ready_o  = ~busy;
  assign pair_valid_o = busy;
  assign w_o          = w_cur;
  assign wp_o         = wp_cur;
  assign round_o      = round;
endmodule

// File: rtl/sm3x_expand_chk.sv
module sm3x_expand_chk
  import sm3x_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              blk_valid_i,
  input logic              blk_ready_o,
  input logic [BLK_W-1:0]  blk_data_i,
  input logic              adv_i,
  input logic              pair_valid_o,
  input logic [WORD_W-1:0] w_o,
  input logic [WORD_W-1:0] wp_o,
  input logic [RND_W-1:0]  round_o
);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(PAIRS - 1);

  a_r5_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_i && blk_ready_o |=> pair_valid_o && !blk_ready_o && round_o == '0);

  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o && adv_i && round_o != LAST_RND
      |=> pair_valid_o && round_o == $past(round_o) + RND_W'(1));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o && !adv_i |=> $stable(w_o) && $stable(wp_o) && $stable(round_o));

  a_r7_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o && adv_i && round_o == LAST_RND
      |=> !pair_valid_o && blk_ready_o && w_o == '0 && wp_o == '0 && round_o == '0);

  a_r8_idle_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_valid_o && !blk_valid_i |=> !pair_valid_o && $stable(w_o) && $stable(round_o));
endmodule

bind sm3x_expand sm3x_expand_chk u_chk (.*);

// File: tb/sm3x_expand_tb_top.sv
module sm3x_expand_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         blk_valid_i = 1'b0;
  logic         blk_ready_o;
  logic [511:0] blk_data_i = '0;
  logic         adv_i = 1'b0;
  logic         pair_valid_o;
  logic [31:0]  w_o, wp_o;
  logic [5:0]   round_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] ref_w [68];

  localparam int NBLK = 4;
  localparam logic [511:0] BLKS [NBLK] = '{
    {32'h61626380, 448'h0, 32'h00000018},
    512'h0,
    {512{1'b1}},
    512'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f202122232425262728292a2b2c2d2e2f303132333435363738393a3b3c3d3e3f
  };

  always #2.5 clk_i = ~clk_i;

  sm3x_expand dut_i (.*);

  function automatic logic [31:0] rl(logic [31:0] x, int r);
    return (x << r) | (x >> (32 - r));
  endfunction

  task automatic build_ref(input logic [511:0] blk);
    for (int i = 0; i < 16; i++) ref_w[i] = blk[511-32*i -: 32];
    for (int i = 16; i < 68; i++) begin
      logic [31:0] t;
      t = ref_w[i-16] ^ ref_w[i-9] ^ rl(ref_w[i-3], 15);
      ref_w[i] = (t ^ rl(t, 15) ^ rl(t, 23)) ^ rl(ref_w[i-13], 7) ^ ref_w[i-6];
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9 ready", 32'(blk_ready_o), 32'd1);
    check("R9 valid", 32'(pair_valid_o), 32'd0);
    check("R9 w", w_o, 32'd0);
    check("R9 wp", wp_o, 32'd0);
    check("R9 round", 32'(round_o), 32'd0);
    rst_ni = 1'b1;
    step();

    // R8: advance while idle has no effect
    adv_i = 1'b1;
    repeat (3) step();
    adv_i = 1'b0;
    check("R8 idle adv valid", 32'(pair_valid_o), 32'd0);
    check("R8 idle adv round", 32'(round_o), 32'd0);
    check("R8 idle adv w", w_o, 32'd0);

    // R1 byte lanes on a counting pattern
    blk_data_i  = BLKS[3];
    blk_valid_i = 1'b1;
    step();
    blk_valid_i = 1'b0;
    check("R1 word0", w_o, 32'h00010203);
    check("R1 wp0", wp_o, 32'h00010203 ^ 32'h10111213);
    adv_i = 1'b1;
    repeat (3) step();
    adv_i = 1'b0;
    check("R1 word3", w_o, 32'h0c0d0e0f);
    adv_i = 1'b1;
    repeat (61) step();
    adv_i = 1'b0;
    check("R7 idle after run", 32'(pair_valid_o), 32'd0);

    // table walk
    for (int b = 0; b < NBLK; b++) begin
      build_ref(BLKS[b]);
      blk_data_i  = BLKS[b];
      blk_valid_i = 1'b1;
      check("R5 ready idle", 32'(blk_ready_o), 32'd1);
      step();
      // R8: block 1 keeps another block offered during its run
      blk_valid_i = (b == 1);
      if (b == 1) blk_data_i = ~BLKS[b];
      for (int j = 0; j < 64; j++) begin
        check("R5/R6 valid", 32'(pair_valid_o), 32'd1);
        check("R5 ready busy", 32'(blk_ready_o), 32'd0);
        check("R6 round", 32'(round_o), 32'(j));
        check(j < 16 ? "R2 w" : "R3 w", w_o, ref_w[j]);
        check("R4 wp", wp_o, ref_w[j] ^ ref_w[j+4]);
        if ((j + b) % 5 == 2) begin
          adv_i = 1'b0;
          step();
          check("R6 hold round", 32'(round_o), 32'(j));
          check("R6 hold w", w_o, ref_w[j]);
          check("R6 hold wp", wp_o, ref_w[j] ^ ref_w[j+4]);
        end
        adv_i = 1'b1;
        step();
        adv_i = 1'b0;
      end
      blk_valid_i = 1'b0;
      check("R7 valid", 32'(pair_valid_o), 32'd0);
      check("R7 ready", 32'(blk_ready_o), 32'd1);
      check("R7 w", w_o, 32'd0);
      check("R7 wp", wp_o, 32'd0);
      check("R7 round", 32'(round_o), 32'd0);
      step();
      check("R8 no stray accept", 32'(pair_valid_o), 32'd0);
    end
    summary();
  end
endmodule